// File: doc/BRIEF.md
# Clock-Stop Power-Down Controller

This block puts a processor into its deepest low-power state by freezing the two-phase clock pair that the core runs from. It watches the decoded instruction stream for one stop opcode. When it sees that opcode, it stops both phase clocks with the first phase parked high and takes the external bus to a quiet state. The address lines keep their last value, the data lines float and the control strobes go inactive. The clocks start again only after an external interrupt line has been held low long enough to count as a real wake event.

Five active-low wake lines feed the block. The non-maskable line always counts. Each of the four general lines counts only when its configuration bit marks it as an interrupt rather than general-purpose I/O. Every line has its own counter of consecutive low samples. A qualified wake starts a short fixed restart delay. After that delay the clocks resume, a one-cycle pulse marks the resumption, and the first phase may start in the opposite sense from before the stop. In emulation mode the stop opcode only puts the block into a watched idle: the clocks keep running so a debugger stays in control, and the same wake rule ends the idle.

Top module: `clkstop_ctrl`

## Requirements
- R1: Synchronous active-high reset leaves `ph1`=1, `ph3`=0, and `stopped`, `idling` and `woken` all at 0.
- R2: While running, `ph1` and `ph3` each invert on every `clk_in` rising edge, and `ph3` always equals the inverse of `ph1`.
- R3: With `instr_valid`=1, `instr_word`=32'h06000001 and `emu_mode`=0 at a rising edge while running, `stopped` reads 1 from that edge on. From the same edge `ph1` is held at 1 and `ph3` at 0, whichever value `ph1` had before. Any other word, or `instr_valid`=0, leaves the clocks toggling and `stopped` at 0.
- R4: While stopped, a wake line counts only after it has been sampled low on `MIN_LOW` (default 4) consecutive rising edges. A high sample restarts its count, so a shorter low pulse leaves the block stopped with the clocks frozen.
- R5: Wake line `irq_n[0]` always counts. Line `irq_n[i]` for i = 1 to 4 counts only when `irq_is_int[i-1]`=1. A low level on a line whose bit is 0 has no effect.
- R6: When a line is first sampled low at edge s+1 while stopped, the wake is recognised at edge s+MIN_LOW+1. `stopped` stays 1 until edge s+MIN_LOW+1+RESTART_DLY (default delay 2). At that edge `stopped` falls and `ph1` makes its first transition, to 0. `woken` is 1 for exactly the one cycle that follows.
- R7: While running, `bus_addr`=`cpu_addr`, `data_hiz`=NOT `cpu_data_oe` and `bus_strobe_n`=`cpu_strobe_n`. While `stopped`=1, `bus_addr` holds the `cpu_addr` value present at the stop edge, `data_hiz`=1 and `bus_strobe_n` is all ones.
- R8: With `emu_mode`=1 the stop opcode sets `idling`=1 and leaves `stopped`=0, with the clocks toggling on. A wake qualified as in R4 and R5 clears `idling` at edge s+MIN_LOW+1, with no restart delay, and `woken` is 1 for the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock, twice the phase-clock rate |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word on `instr_word` is valid this cycle |
| instr_word | input | 32 | Decoded instruction word |
| irq_n | input | 5 | Active-low wake lines; bit 0 is the non-maskable line |
| irq_is_int | input | 4 | Per general line: 1 = interrupt, 0 = general-purpose I/O |
| emu_mode | input | 1 | Emulation mode: stop becomes a clocks-running idle |
| cpu_addr | input | ADDR_W | Address from the core |
| cpu_data_oe | input | 1 | Core wants to drive the data lines |
| cpu_strobe_n | input | STB_W | Active-low control strobes from the core |
| ph1 | output | 1 | First phase clock |
| ph3 | output | 1 | Second phase clock, inverse of `ph1` |
| bus_addr | output | ADDR_W | Address to the external bus |
| data_hiz | output | 1 | 1 = data lines high-impedance |
| bus_strobe_n | output | STB_W | Active-low control strobes to the bus |
| stopped | output | 1 | Clocks are frozen (stopped or restarting) |
| idling | output | 1 | Emulation idle in progress |
| woken | output | 1 | One-cycle pulse when the clocks resume |

## Verification
The bench issues the stop with `ph1` both high and low, because a design that freezes without parking would hold the first phase low on one of the two paths. It sends a low pulse one sample shorter than the threshold, then holds a general line low while that line is set as I/O. A counter that never resets, or a missing configuration mask, would wake the block early in these cases. The resume edge is timed to the exact cycle against `MIN_LOW` and the restart delay, which catches any wrong count. The address-hold check changes `cpu_addr` during the stop, so a design that passes the address through is exposed. The emulation pass checks that the clocks never freeze, that `stopped` stays low and that the idle ends with a single `woken` pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

    // Instruction word that requests the clock-stop state
    localparam logic [31:0] STOP_OPCODE = 32'h0600_0001;

    // Non-maskable line plus four general lines
    localparam int NUM_WAKE = 5;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HALT   = 2'd1,
        ST_RESUME = 2'd2,
        ST_EIDLE  = 2'd3
    } seq_state_e;

    // Control bundle from the sequencer to the rest of the block
    typedef struct packed {
        logic halted;   // clocks frozen, bus quiet
        logic idle;     // emulation idle, clocks running
        logic arm;      // wake counters may count
        logic adv;      // phase clocks advance at this edge
        logic woken;    // resume pulse
    } seq_ctl_t;

    function automatic logic is_stop_word(input logic valid, input logic [31:0] word);
        return valid && (word == STOP_OPCODE);
    endfunction

    // Line 0 always wakes; the others follow their configuration bits
    function automatic logic [NUM_WAKE-1:0] wake_enables(input logic [NUM_WAKE-2:0] cfg);
        return {cfg, 1'b1};
    endfunction

endpackage

// File: rtl/clkstop_wake_qual.sv
module clkstop_wake_qual
    import clkstop_pkg::*;
#(
    parameter int NSRC    = NUM_WAKE,
    parameter int MIN_LOW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            arm,
    input  logic [NSRC-1:0] pin_n,
    input  logic [NSRC-1:0] src_en,
    output logic [NSRC-1:0] qual,
    output logic            wake_any
);

    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] SAT = CW'(MIN_LOW);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [CW-1:0] low_cnt;

        always_ff @(posedge clk) begin
            if (rst || !arm || pin_n[g] || !src_en[g]) begin
                low_cnt <= '0;
            end else if (low_cnt != SAT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end

        assign qual[g] = (low_cnt == SAT);

        // R4: a high sample on the line withdraws its qualification
        p_cnt_clear_r4: assert property (@(posedge clk) disable iff (rst)
            pin_n[g] |=> !qual[g]);

        // R5: a line masked as general-purpose I/O never qualifies
        p_masked_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            !src_en[g] |=> !qual[g]);
    end

    assign wake_any = |qual;

endmodule

// File: rtl/clkstop_phase_gen.sv
module clkstop_phase_gen (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic ph1,
    output logic ph3
);

    // Two separate flops; they must never agree
    always_ff @(posedge clk) begin
        if (rst) begin
            ph1 <= 1'b1;
            ph3 <= 1'b0;
        end else if (adv) begin
            ph1 <= ~ph1;
            ph3 <= ~ph3;
        end
    end

    p_ph_opposite_r2: assert property (@(posedge clk) disable iff (rst)
        ph1 != ph3);

endmodule

// File: rtl/clkstop_seq.sv
module clkstop_seq
    import clkstop_pkg::*;
#(
    parameter int RESTART_DLY = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     stop_req,
    input  logic     emu_mode,
    input  logic     wake_any,
    input  logic     ph1,
    output seq_ctl_t ctl
);

    localparam int DW = (RESTART_DLY > 1) ? $clog2(RESTART_DLY) : 1;
    localparam logic [DW-1:0] DLY_LAST = DW'(RESTART_DLY - 1);

    seq_state_e state, state_nx;
    logic [DW-1:0] dly_cnt;
    logic          woken_q;
    logic          resume_now;
    logic          adv;

    always_comb begin
        state_nx   = state;
        adv        = 1'b0;
        resume_now = 1'b0;
        case (state)
            ST_RUN: begin
                if (stop_req && emu_mode) begin
                    adv      = 1'b1;
                    state_nx = ST_EIDLE;
                end else if (stop_req) begin
                    // park with the first phase high
                    adv      = !ph1;
                    state_nx = ST_HALT;
                end else begin
                    adv = 1'b1;
                end
            end
            ST_HALT: begin
                if (wake_any) state_nx = ST_RESUME;
            end
            ST_RESUME: begin
                if (dly_cnt == DLY_LAST) begin
                    adv        = 1'b1;
                    resume_now = 1'b1;
                    state_nx   = ST_RUN;
                end
            end
            ST_EIDLE: begin
                adv = 1'b1;
                if (wake_any) begin
                    resume_now = 1'b1;
                    state_nx   = ST_RUN;
                end
            end
            default: state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            dly_cnt <= '0;
            woken_q <= 1'b0;
        end else begin
            state   <= state_nx;
            woken_q <= resume_now;
            if (state != ST_RESUME) dly_cnt <= '0;
            else                    dly_cnt <= dly_cnt + 1'b1;
        end
    end

    assign ctl.halted = (state == ST_HALT) || (state == ST_RESUME);
    assign ctl.idle   = (state == ST_EIDLE);
    assign ctl.arm    = (state == ST_HALT) || (state == ST_EIDLE);
    assign ctl.adv    = adv;
    assign ctl.woken  = woken_q;

    // R3: the frozen clock is parked with the first phase high
    p_park_high_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT) |-> ph1);

    // R4: without a qualified line the block stays stopped
    p_no_early_wake_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HALT && !wake_any) |=> (state == ST_HALT));

    // R6: the resume marker is a single-cycle pulse
    p_woken_single_r6: assert property (@(posedge clk) disable iff (rst)
        woken_q |=> !woken_q);

    // R8: under emulation a stop request never freezes the clocks
    p_emu_no_halt_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && stop_req && emu_mode) |=> (state == ST_EIDLE));

endmodule

// File: rtl/clkstop_bus_gate.sv
module clkstop_bus_gate #(
    parameter int ADDR_W = 24,
    parameter int STB_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              halted,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_data_oe,
    input  logic [STB_W-1:0]  cpu_strobe_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              data_hiz,
    output logic [STB_W-1:0]  bus_strobe_n
);

    logic [ADDR_W-1:0] addr_q;

    // Capture the address on every running edge; the stop edge leaves the last one
    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (!halted) addr_q <= cpu_addr;
    end

    assign bus_addr     = halted ? addr_q : cpu_addr;
    assign data_hiz     = halted | ~cpu_data_oe;
    assign bus_strobe_n = halted ? {STB_W{1'b1}} : cpu_strobe_n;

    p_addr_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> $stable(bus_addr));

    p_strobe_idle_r7: assert property (@(posedge clk) disable iff (rst)
        halted |-> (&bus_strobe_n));

    p_data_float_r7: assert property (@(posedge clk) disable iff (rst)
        halted |-> data_hiz);

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int STB_W       = 3,
    parameter int MIN_LOW     = 4,
    parameter int RESTART_DLY = 2
) (
    input  logic                clk_in,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [31:0]         instr_word,
    input  logic [NUM_WAKE-1:0] irq_n,
    input  logic [NUM_WAKE-2:0] irq_is_int,
    input  logic                emu_mode,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_data_oe,
    input  logic [STB_W-1:0]    cpu_strobe_n,
    output logic                ph1,
    output logic                ph3,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                data_hiz,
    output logic [STB_W-1:0]    bus_strobe_n,
    output logic                stopped,
    output logic                idling,
    output logic                woken
);

    seq_ctl_t            ctl;
    logic                stop_req;
    logic                wake_any;
    logic [NUM_WAKE-1:0] src_en;
    logic [NUM_WAKE-1:0] qual;

    assign stop_req = is_stop_word(instr_valid, instr_word);
    assign src_en   = wake_enables(irq_is_int);

    clkstop_wake_qual #(
        .NSRC    (NUM_WAKE),
        .MIN_LOW (MIN_LOW)
    ) u_wake (
        .clk      (clk_in),
        .rst      (rst),
        .arm      (ctl.arm),
        .pin_n    (irq_n),
        .src_en   (src_en),
        .qual     (qual),
        .wake_any (wake_any)
    );

    clkstop_seq #(
        .RESTART_DLY (RESTART_DLY)
    ) u_seq (
        .clk      (clk_in),
        .rst      (rst),
        .stop_req (stop_req),
        .emu_mode (emu_mode),
        .wake_any (wake_any),
        .ph1      (ph1),
        .ctl      (ctl)
    );

    clkstop_phase_gen u_phase (
        .clk (clk_in),
        .rst (rst),
        .adv (ctl.adv),
        .ph1 (ph1),
        .ph3 (ph3)
    );

    clkstop_bus_gate #(
        .ADDR_W (ADDR_W),
        .STB_W  (STB_W)
    ) u_bus (
        .clk          (clk_in),
        .rst          (rst),
        .halted       (ctl.halted),
        .cpu_addr     (cpu_addr),
        .cpu_data_oe  (cpu_data_oe),
        .cpu_strobe_n (cpu_strobe_n),
        .bus_addr     (bus_addr),
        .data_hiz     (data_hiz),
        .bus_strobe_n (bus_strobe_n)
    );

    assign stopped = ctl.halted;
    assign idling  = ctl.idle;
    assign woken   = ctl.woken;

    // R6: a pulse on woken never coincides with frozen clocks
    p_woken_running_r6: assert property (@(posedge clk_in) disable iff (rst)
        woken |-> !stopped);

endmodule

// File: tb/clkstop_ctrl_test.sv
module clkstop_ctrl_test;
    import clkstop_pkg::*;

    localparam int AW   = 24;
    localparam int NSTB = 3;
    localparam int MINL = 4;
    localparam int DLY  = 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [31:0]     instr_word = '0;
    logic [4:0]      irq_n = 5'b11111;
    logic [3:0]      irq_is_int = 4'b0000;
    logic            emu_mode = 1'b0;
    logic [AW-1:0]   cpu_addr = '0;
    logic            cpu_data_oe = 1'b0;
    logic [NSTB-1:0] cpu_strobe_n = '1;
    logic            ph1, ph3, data_hiz, stopped, idling, woken;
    logic [AW-1:0]   bus_addr;
    logic [NSTB-1:0] bus_strobe_n;

    always #10 clk = ~clk;   // 50 MHz

    clkstop_ctrl #(
        .ADDR_W(AW), .STB_W(NSTB), .MIN_LOW(MINL), .RESTART_DLY(DLY)
    ) uut (
        .clk_in(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .irq_n(irq_n), .irq_is_int(irq_is_int), .emu_mode(emu_mode),
        .cpu_addr(cpu_addr), .cpu_data_oe(cpu_data_oe), .cpu_strobe_n(cpu_strobe_n),
        .ph1(ph1), .ph3(ph3), .bus_addr(bus_addr), .data_hiz(data_hiz),
        .bus_strobe_n(bus_strobe_n), .stopped(stopped), .idling(idling), .woken(woken)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    typedef struct {
        int         at;
        string      tag;
        logic [4:0] v;    // {ph1, ph3, stopped, idling, woken}
    } exp_t;
    exp_t sb[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic exp_at(input int at, input string tag, input logic p1,
                          input logic st, input logic idl, input logic wk);
        exp_t e;
        e.at  = at;
        e.tag = tag;
        e.v   = {p1, ~p1, st, idl, wk};
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(e.tag, {27'd0, ph1, ph3, stopped, idling, woken}, {27'd0, e.v});
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Issue the stop word when ph1 has the requested value; returns the cycle before E0
    task automatic issue_stop(input logic want_ph1, input logic emu,
                              input logic [AW-1:0] a, output int c);
        while (ph1 !== want_ph1) @(negedge clk);
        c           = cyc;
        emu_mode    = emu;
        cpu_addr    = a;
        instr_valid = 1'b1;
        instr_word  = STOP_OPCODE;
        if (!emu) begin
            exp_at(c + 1, "R3 stop parks ph1 high", 1'b1, 1'b1, 1'b0, 1'b0);
            exp_at(c + 2, "R3 clocks stay frozen",  1'b1, 1'b1, 1'b0, 1'b0);
        end else begin
            exp_at(c + 1, "R8 emu idle clocks run", ~want_ph1, 1'b0, 1'b1, 1'b0);
            exp_at(c + 2, "R8 emu idle clocks run",  want_ph1, 1'b0, 1'b1, 1'b0);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = '0;
        cpu_addr    = ~a;
    endtask

    // Hold one line low from the current negedge and expect the timed resume
    task automatic timed_wake(input int line, input string tag);
        int s, w;
        s = cyc;
        w = s + MINL + 1 + DLY;
        irq_n[line] = 1'b0;
        for (int k = s + 2; k < w; k++) exp_at(k, {tag, " R4 held until qualified"}, 1'b1, 1'b1, 1'b0, 1'b0);
        exp_at(w,     {tag, " R6 resume edge"},   1'b0, 1'b0, 1'b0, 1'b1);
        exp_at(w + 1, {tag, " R6 woken one cycle"}, 1'b1, 1'b0, 1'b0, 1'b0);
        exp_at(w + 2, {tag, " R2 running again"}, 1'b0, 1'b0, 1'b0, 1'b0);
        tick(w + 2 - s);
        irq_n[line] = 1'b1;
    endtask

    initial begin
        int c, s, p;
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        chk("R1 reset outputs", {27'd0, ph1, ph3, stopped, idling, woken}, {27'd0, 5'b10000});

        // R2: free-running phase clocks
        c = cyc; p = ph1;
        for (int k = 1; k <= 4; k++) exp_at(c + k, "R2 toggle each edge", 1'(p ^ k), 1'b0, 1'b0, 1'b0);
        tick(4);

        // R3: a different word and an invalid stop word are ignored
        c = cyc; p = ph1;
        for (int k = 1; k <= 3; k++) exp_at(c + k, "R3 non-stop ignored", 1'(p ^ k), 1'b0, 1'b0, 1'b0);
        instr_valid = 1'b1; instr_word = 32'h0600_0003;
        tick(1);
        instr_valid = 1'b0; instr_word = STOP_OPCODE;
        tick(2);
        instr_word = '0;

        // R7: pass-through while running
        cpu_addr = 24'h012345; cpu_data_oe = 1'b1; cpu_strobe_n = 3'b101;
        #1;
        chk("R7 run addr pass", {8'd0, bus_addr}, {8'd0, 24'h012345});
        chk("R7 run data driven", {31'd0, data_hiz}, 32'd0);
        chk("R7 run strobes pass", {29'd0, bus_strobe_n}, {29'd0, 3'b101});
        cpu_data_oe = 1'b0;
        #1;
        chk("R7 run data released", {31'd0, data_hiz}, 32'd1);
        cpu_data_oe = 1'b1;
        tick(1);

        // R3: stop with ph1 high at the request
        issue_stop(1'b1, 1'b0, 24'hABCDE0, c);
        #1;
        chk("R7 stop addr held", {8'd0, bus_addr}, {8'd0, 24'hABCDE0});
        chk("R7 stop data hiz", {31'd0, data_hiz}, 32'd1);
        chk("R7 stop strobes idle", {29'd0, bus_strobe_n}, {29'd0, 3'b111});

        // R4: a pulse one sample short does not wake
        tick(1);
        s = cyc;
        for (int k = 1; k <= 8; k++) exp_at(s + k, "R4 short pulse ignored", 1'b1, 1'b1, 1'b0, 1'b0);
        irq_n[0] = 1'b0;
        tick(MINL - 1);
        irq_n[0] = 1'b1;
        tick(8 - (MINL - 1));

        // R5: a general line configured as I/O does not wake
        irq_is_int = 4'b0100;
        s = cyc;
        for (int k = 1; k <= 8; k++) exp_at(s + k, "R5 io line ignored", 1'b1, 1'b1, 1'b0, 1'b0);
        irq_n[2] = 1'b0;
        tick(8);
        irq_n[2] = 1'b1;
        #1;
        chk("R7 addr still held", {8'd0, bus_addr}, {8'd0, 24'hABCDE0});

        // R6: configured general line wakes with exact timing
        timed_wake(3, "line3");
        #1;
        chk("R7 addr follows after resume", {8'd0, bus_addr}, {8'd0, ~24'hABCDE0});

        // R3: stop with ph1 low at the request; R5: the non-maskable line ignores the mask
        irq_is_int = 4'b0000;
        tick(1);
        issue_stop(1'b0, 1'b0, 24'h00F00D, c);
        #1;
        chk("R7 second stop addr held", {8'd0, bus_addr}, {8'd0, 24'h00F00D});
        tick(1);
        timed_wake(0, "nmi R5");

        // R8: emulation idle keeps clocks running and ends on a qualified wake
        irq_is_int = 4'b0001;
        tick(1);
        issue_stop(1'b1, 1'b1, 24'h000777, c);
        #1;
        chk("R8 emu bus not quieted", {31'd0, data_hiz}, 32'd0);
        s = cyc; p = ph1;
        for (int k = 2; k <= MINL; k++) exp_at(s + k, "R8 idle while qualifying", 1'(p ^ k), 1'b0, 1'b1, 1'b0);
        exp_at(s + MINL + 1, "R8 idle ends with woken", 1'(p ^ (MINL + 1)), 1'b0, 1'b0, 1'b1);
        exp_at(s + MINL + 2, "R8 woken one cycle",      1'(p ^ (MINL + 2)), 1'b0, 1'b0, 1'b0);
        irq_n[1] = 1'b0;
        tick(MINL + 3);
        irq_n[1] = 1'b1;
        emu_mode = 1'b0;

        tick(3);
        done = 1;
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL scoreboard: actual=%0d expected=0 pending items", sb.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule